// File: doc/BRIEF.md
# Pipelined 23-bit Floating-Point Adder/Subtractor

This block adds or subtracts two numbers held in a compact 23-bit floating-point word meant for FPGA signal-processing datapaths, such as the sum and difference paths of a radix-2 FFT butterfly. Each word has a 6-bit exponent with a bias of 31, a sign bit and a 16-bit stored fraction under an implied leading one. A value equals (-1)^sign × 2^(exponent − 31) × 1.fraction. The format has no infinities, no NaNs and no denormals. Rounding is by truncation only.

One operand pair and a mode bit are accepted on every clock while `in_valid` is high. The pipeline has three register stages. The first stage orders the operands by magnitude and shifts the smaller significand right by the exponent gap. The second stage adds or subtracts the significands. The third stage renormalises the result, handles zero, underflow and overflow, and packs the output word. The result appears exactly three clocks later with `out_valid`.

The datapath is a straight pipeline, so it has no state machine. The only sequencing is the valid bit, which moves one stage per clock.

Top module: `fp23_addsub`

## Requirements
- R1: The word layout is exponent in bits [22:17], sign in bit 16 and fraction in bits [15:0]. An operand whose exponent field is 0 is treated as zero whatever its fraction bits hold. A zero result is emitted as the all-zero word.
- R2: With `in_sub` = 0 and operands of equal sign, the result is the magnitude sum with that sign. A carry out of the significand raises the exponent by one and drops the lowest bit.
- R3: With `in_sub` = 1, the result is `in_a` minus `in_b`, which is computed as `in_a` plus `in_b` with its sign bit inverted.
- R4: The significand of the smaller-magnitude operand is shifted right by the exponent difference, and the bits shifted out are discarded (truncation).
- R5: When the exponents differ by 17 or more, or when one operand is zero, the result equals the larger operand bit for bit. If that operand is `in_b`, its sign is inverted when `in_sub` = 1.
- R6: After an effective subtraction, the result is shifted left until its leading one reaches the hidden position, and the exponent is lowered by the same count.
- R7: An exact cancellation yields the all-zero word. So does a renormalised exponent below 1.
- R8: A carry that would push the exponent past 63 saturates the result to exponent 63 and fraction 0xFFFF, keeping the sign of the larger operand.
- R9: `out_valid` equals `in_valid` delayed by exactly three clocks, and a new operand pair may arrive on every clock.
- R10: During and after reset, and on every cycle in which `out_valid` is low, `out_res` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is valid this cycle |
| in_a | input | 23 | First operand |
| in_b | input | 23 | Second operand |
| in_sub | input | 1 | 1 selects a − b, 0 selects a + b |
| out_valid | output | 1 | Result word is valid |
| out_res | output | 23 | Result word |

## Verification
The pipeline holds per-stage state: the magnitude ordering, the aligned significand, the effective operation and the raw sum. A fault in any of these shows at the ports three clocks after the affected input, as a wrong sign, a wrong exponent or a fraction that is off by the lost or gained bits. A misrouted valid bit shows on the same clock as a result that is missing or extra, or as a nonzero word while `out_valid` is low. The reference model predicts every cycle's output word and valid bit from the inputs three cycles earlier. A single wrong bit in a swap decision, a shift amount or a leading-zero count is therefore reported on the first cycle it reaches the output.

// File: rtl/fp23_pkg.sv
package fp23_pkg;
    localparam int FP_EXP_W = 6;
    localparam int FP_MAN_W = 16;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;
endpackage

// File: rtl/fp23_align.sv
module fp23_align
    import fp23_pkg::*;
#(
    parameter int EXP_W = FP_EXP_W,
    parameter int MAN_W = FP_MAN_W,
    localparam int W    = EXP_W + 1 + MAN_W,
    localparam int SIG  = MAN_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [W-1:0]     in_a,
    input  logic [W-1:0]     in_b,
    input  logic             in_sub,
    output logic             s1_valid,
    output logic             s1_sign,
    output logic [EXP_W-1:0] s1_exp,
    output logic [SIG-1:0]   s1_big,
    output logic [SIG-1:0]   s1_small,
    output op_e              s1_op
);
    logic [EXP_W-1:0] ea, eb, el, es, diff;
    logic [SIG-1:0]   ma, mb, ml, ms, sh;
    logic             sa, sb, sl, a_big;

    always_comb begin
        ea    = in_a[W-1 -: EXP_W];
        eb    = in_b[W-1 -: EXP_W];
        sa    = in_a[MAN_W];
        sb    = in_b[MAN_W] ^ in_sub;
        ma    = (ea == '0) ? '0 : {1'b1, in_a[MAN_W-1:0]};
        mb    = (eb == '0) ? '0 : {1'b1, in_b[MAN_W-1:0]};
        a_big = (ea > eb) || ((ea == eb) && (ma >= mb));
        el    = a_big ? ea : eb;
        es    = a_big ? eb : ea;
        ml    = a_big ? ma : mb;
        ms    = a_big ? mb : ma;
        sl    = a_big ? sa : sb;
        diff  = el - es;
        sh    = (int'(diff) >= SIG) ? '0 : (ms >> diff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_sign  <= 1'b0;
            s1_exp   <= '0;
            s1_big   <= '0;
            s1_small <= '0;
            s1_op    <= OP_ADD;
        end else begin
            s1_valid <= in_valid;
            s1_sign  <= sl;
            s1_exp   <= el;
            s1_big   <= ml;
            s1_small <= sh;
            s1_op    <= (sa == sb) ? OP_ADD : OP_SUB;
        end
    end
endmodule

// File: rtl/fp23_combine.sv
module fp23_combine
    import fp23_pkg::*;
#(
    parameter int EXP_W = FP_EXP_W,
    parameter int MAN_W = FP_MAN_W,
    localparam int SIG  = MAN_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s1_valid,
    input  logic             s1_sign,
    input  logic [EXP_W-1:0] s1_exp,
    input  logic [SIG-1:0]   s1_big,
    input  logic [SIG-1:0]   s1_small,
    input  op_e              s1_op,
    output logic             s2_valid,
    output logic             s2_sign,
    output logic [EXP_W-1:0] s2_exp,
    output logic [SIG:0]     s2_sum
);
    logic [SIG:0] raw;

    always_comb begin
        unique case (s1_op)
            OP_ADD: raw = {1'b0, s1_big} + {1'b0, s1_small};
            OP_SUB: raw = {1'b0, s1_big} - {1'b0, s1_small};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            s2_sign  <= 1'b0;
            s2_exp   <= '0;
            s2_sum   <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_sign  <= s1_sign;
            s2_exp   <= s1_exp;
            s2_sum   <= raw;
        end
    end
endmodule

// File: rtl/fp23_renorm.sv
module fp23_renorm
    import fp23_pkg::*;
#(
    parameter int EXP_W = FP_EXP_W,
    parameter int MAN_W = FP_MAN_W,
    localparam int W    = EXP_W + 1 + MAN_W,
    localparam int SIG  = MAN_W + 1,
    localparam int LZW  = $clog2(SIG + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s2_valid,
    input  logic             s2_sign,
    input  logic [EXP_W-1:0] s2_exp,
    input  logic [SIG:0]     s2_sum,
    output logic             out_valid,
    output logic [W-1:0]     out_res
);
    logic [LZW-1:0]   lz;
    logic             hit;
    logic [SIG-1:0]   norm;
    logic [EXP_W:0]   e_dn;
    logic [EXP_W-1:0] e_up;
    logic [W-1:0]     packed_res;

    always_comb begin
        lz  = '0;
        hit = 1'b0;
        for (int i = MAN_W; i >= 0; i--) begin
            if (!hit) begin
                if (s2_sum[i]) hit = 1'b1;
                else           lz  = lz + 1'b1;
            end
        end
        norm = s2_sum[SIG-1:0] << lz;
        e_dn = {1'b0, s2_exp} - (EXP_W+1)'(lz);
        e_up = s2_exp + 1'b1;

        if (s2_sum == '0) begin
            packed_res = '0;
        end else if (s2_sum[SIG]) begin
            if (s2_exp == '1) packed_res = {{EXP_W{1'b1}}, s2_sign, {MAN_W{1'b1}}};
            else              packed_res = {e_up, s2_sign, s2_sum[MAN_W:1]};
        end else if (e_dn[EXP_W] || (e_dn == '0)) begin
            packed_res = '0;
        end else begin
            packed_res = {e_dn[EXP_W-1:0], s2_sign, norm[MAN_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= s2_valid;
            out_res   <= s2_valid ? packed_res : '0;
        end
    end
endmodule

// File: rtl/fp23_addsub.sv
module fp23_addsub
    import fp23_pkg::*;
#(
    parameter int EXP_W = FP_EXP_W,
    parameter int MAN_W = FP_MAN_W,
    localparam int W    = EXP_W + 1 + MAN_W,
    localparam int SIG  = MAN_W + 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic         in_sub,
    output logic         out_valid,
    output logic [W-1:0] out_res
);
    logic             s1_valid, s1_sign;
    logic [EXP_W-1:0] s1_exp;
    logic [SIG-1:0]   s1_big, s1_small;
    op_e              s1_op;
    logic             s2_valid, s2_sign;
    logic [EXP_W-1:0] s2_exp;
    logic [SIG:0]     s2_sum;

    fp23_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_sub(in_sub), .s1_valid(s1_valid), .s1_sign(s1_sign), .s1_exp(s1_exp),
        .s1_big(s1_big), .s1_small(s1_small), .s1_op(s1_op)
    );

    fp23_combine #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_combine (
        .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_sign(s1_sign),
        .s1_exp(s1_exp), .s1_big(s1_big), .s1_small(s1_small), .s1_op(s1_op),
        .s2_valid(s2_valid), .s2_sign(s2_sign), .s2_exp(s2_exp), .s2_sum(s2_sum)
    );

    fp23_renorm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_renorm (
        .clk(clk), .rst(rst), .s2_valid(s2_valid), .s2_sign(s2_sign),
        .s2_exp(s2_exp), .s2_sum(s2_sum), .out_valid(out_valid), .out_res(out_res)
    );
endmodule

// File: rtl/fp23_addsub_chk.sv
module fp23_addsub_chk #(
    parameter int EXP_W = 6,
    parameter int MAN_W = 16,
    localparam int W    = EXP_W + 1 + MAN_W,
    localparam int SIG  = MAN_W + 1
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] in_a,
    input logic [W-1:0] in_b,
    input logic         in_sub,
    input logic         out_valid,
    input logic [W-1:0] out_res
);
    logic [2:0]   vh;
    logic [W-1:0] ah [3];
    logic [W-1:0] bh [3];
    logic [2:0]   sh;
    logic         far_a, far_b;
    int           ea, eb;

    always_ff @(posedge clk) begin
        if (rst) begin
            vh <= '0;
            sh <= '0;
            for (int i = 0; i < 3; i++) begin
                ah[i] <= '0;
                bh[i] <= '0;
            end
        end else begin
            vh <= {vh[1:0], in_valid};
            sh <= {sh[1:0], in_sub};
            ah[0] <= in_a;
            bh[0] <= in_b;
            for (int i = 1; i < 3; i++) begin
                ah[i] <= ah[i-1];
                bh[i] <= bh[i-1];
            end
        end
    end

    always_comb begin
        ea    = int'(ah[2][W-1 -: EXP_W]);
        eb    = int'(bh[2][W-1 -: EXP_W]);
        far_a = (ea != 0) && ((eb == 0) || (ea >= eb + SIG));
        far_b = (eb != 0) && ((ea == 0) || (eb >= ea + SIG));
    end

    // R9: valid emerges three clocks after it entered
    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid == vh[2]);

    // R10: no data on idle cycles
    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_res == '0);

    // R7: a zero exponent field only ever appears in the all-zero word
    p_zero_form_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_res[W-1 -: EXP_W] == '0) |-> out_res == '0);

    // R5: a far-smaller operand leaves the larger one untouched
    p_far_a_r5: assert property (@(posedge clk) disable iff (rst)
        (vh[2] && far_a) |-> out_res == ah[2]);

    p_far_b_r5: assert property (@(posedge clk) disable iff (rst)
        (vh[2] && far_b) |-> out_res == {bh[2][W-1:MAN_W+1], bh[2][MAN_W] ^ sh[2], bh[2][MAN_W-1:0]});
endmodule

bind fp23_addsub fp23_addsub_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_sub(in_sub), .out_valid(out_valid), .out_res(out_res)
);

// File: tb/tb_fp23_addsub.sv
`timescale 1ns/1ps
module tb_fp23_addsub;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [22:0] in_a = '0;
    logic [22:0] in_b = '0;
    logic        in_sub = 1'b0;
    logic        out_valid;
    logic [22:0] out_res;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    bit          q_v[$];
    logic [22:0] q_w[$];
    string       q_t[$];

    always #4 clk = ~clk;

    fp23_addsub dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_sub(in_sub), .out_valid(out_valid), .out_res(out_res)
    );

    function automatic logic [22:0] mk(int e, bit s, int m);
        return {e[5:0], s, m[15:0]};
    endfunction

    function automatic logic [22:0] model(logic [22:0] a, logic [22:0] b, bit sub);
        int ea, eb, ma, mb, el, es, ml, ms, d, r, e;
        bit sa, sb, sl, abig;
        ea = a[22:17]; eb = b[22:17];
        sa = a[16];    sb = b[16] ^ sub;
        ma = (ea == 0) ? 0 : 65536 + a[15:0];
        mb = (eb == 0) ? 0 : 65536 + b[15:0];
        abig = (ea > eb) || (ea == eb && ma >= mb);
        el = abig ? ea : eb;  es = abig ? eb : ea;
        ml = abig ? ma : mb;  ms = abig ? mb : ma;
        sl = abig ? sa : sb;
        d  = el - es;
        ms = (d >= 17) ? 0 : (ms >> d);
        r  = (sa == sb) ? ml + ms : ml - ms;
        e  = el;
        if (r == 0) return '0;
        if (r >= 131072) begin
            r = r >> 1;
            e = e + 1;
            if (e > 63) return {6'h3f, sl, 16'hffff};
        end
        while (r < 65536) begin
            r = r << 1;
            e = e - 1;
        end
        if (e < 1) return '0;
        return {e[5:0], sl, r[15:0]};
    endfunction

    task automatic check_head();
        bit ev; logic [22:0] ew; string tg;
        ev = q_v.pop_front(); ew = q_w.pop_front(); tg = q_t.pop_front();
        n_checks++;
        if (out_valid !== ev || out_res !== ew) begin
            n_errors++;
            $display("FAIL %s: got valid=%0b res=%h, expected valid=%0b res=%h",
                     tg, out_valid, out_res, ev, ew);
        end
    endtask

    task automatic step(bit v, logic [22:0] a, logic [22:0] b, bit sub, string tg);
        @(negedge clk);
        check_head();
        in_valid = v; in_a = a; in_b = b; in_sub = sub;
        q_v.push_back(v);
        q_w.push_back(v ? model(a, b, sub) : 23'h0);
        q_t.push_back(tg);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state visible at the ports
        n_checks++;
        if (out_valid !== 1'b0 || out_res !== '0) begin
            n_errors++;
            $display("FAIL R10: got valid=%0b res=%h, expected valid=0 res=0", out_valid, out_res);
        end
        rst = 1'b0;
        repeat (3) begin q_v.push_back(0); q_w.push_back('0); q_t.push_back("R10"); end

        // R1: zero-exponent operand counts as zero whatever its fraction holds
        step(1, mk(0, 0, 16'h1234), mk(31, 0, 0), 0, "R1");
        step(1, mk(0, 1, 16'hffff), mk(0, 0, 16'h0001), 0, "R1");
        // R2: same-sign additions, with carry
        step(1, mk(31, 0, 0), mk(31, 0, 0), 0, "R2");
        step(1, mk(33, 1, 16'h4000), mk(32, 1, 16'h8001), 0, "R2");
        // R3: subtract mode flips b
        step(1, mk(32, 0, 16'h8000), mk(31, 0, 0), 1, "R3");
        step(1, mk(31, 0, 0), mk(32, 0, 16'h8000), 1, "R3");
        step(1, mk(31, 1, 0), mk(31, 1, 0), 1, "R3");
        // R4: truncating alignment shifts
        step(1, mk(40, 0, 16'h0000), mk(37, 0, 16'hffff), 0, "R4");
        step(1, mk(40, 0, 16'h0000), mk(25, 0, 16'h0007), 0, "R4");
        // R5: gap of 17 or more, and zero operands
        step(1, mk(50, 0, 16'h1111), mk(33, 0, 16'hffff), 0, "R5");
        step(1, mk(20, 1, 16'h2222), mk(45, 0, 16'h3333), 1, "R5");
        step(1, mk(30, 0, 16'h4444), mk(0, 0, 0), 1, "R5");
        // R6: cancellation with renormalisation
        step(1, mk(31, 0, 16'h8000), mk(31, 0, 16'h4000), 1, "R6");
        step(1, mk(31, 0, 16'h0001), mk(31, 1, 16'h0000), 0, "R6");
        step(1, mk(31, 0, 16'h0000), mk(30, 0, 16'hffff), 1, "R6");
        // R7: exact zero and underflow
        step(1, mk(12, 0, 16'habcd), mk(12, 0, 16'habcd), 1, "R7");
        step(1, mk(2, 0, 16'h0001), mk(2, 0, 16'h0000), 1, "R7");
        step(1, mk(1, 0, 16'h8000), mk(1, 1, 16'h0000), 0, "R7");
        // R8: overflow saturates with sign
        step(1, mk(63, 0, 0), mk(63, 0, 0), 0, "R8");
        step(1, mk(63, 1, 16'h8000), mk(62, 0, 16'hffff), 1, "R8");
        step(1, mk(62, 0, 16'hffff), mk(62, 0, 16'hffff), 0, "R8");
        // R9/R10: bubbles between valid words
        step(0, mk(31, 0, 0), mk(31, 0, 0), 0, "R10");
        step(1, mk(35, 0, 16'h0f0f), mk(34, 1, 16'hf0f0), 0, "R9");
        step(0, mk(9, 0, 1), mk(9, 0, 1), 0, "R10");
        step(0, '0, '0, 0, "R10");
        // R9: random stream, mixed validity, near exponents for deep cancellation
        for (int i = 0; i < 3000; i++) begin
            logic [22:0] a, b;
            a = $urandom;
            b = $urandom;
            if (i % 3 == 0) b[22:17] = a[22:17] + 6'($urandom_range(0, 2));
            step(($urandom % 4) != 0, a, b, $urandom % 2, "R9");
        end
        repeat (3) step(0, '0, '0, 0, "R10");
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule